// File: doc/BRIEF.md
# PHY Interrupt Source Controller

This block gathers the status events of one Ethernet PHY port into a register of sticky source flags. Each flag is set by the edge of one internal status signal: a remote fault, loss of link, a link-partner acknowledge, a parallel-detection fault, a received page, a change in energy detection and a wake-on-LAN match. Each flag also has its own list of clearing triggers. An eight-bit mask selects which flags drive the single interrupt output. Register reads, the auto-negotiation restart and flag-register writes arrive as one-cycle decoded strobes from the management logic around the block.

Two clearing schemes are available. In the primary scheme a flag drops on the falling edge of its source, on reads of particular registers (1, 6 or 29), on an auto-negotiation restart, or on link loss. In the alternate scheme all of those triggers are ignored. Writing a one to a flag bit makes the block re-examine the source. The flag clears only if the source is already inactive.

The energy status is produced inside the block by a three-state machine. `EN_ACQUIRE` is entered at reset and reports energy present while a cycle counter runs. `EN_ACQUIRE -> EN_PRESENT` is taken when a signal is seen, and `EN_ACQUIRE -> EN_ABSENT` when the counter reaches `ACQ_CYCLES` with no signal. After that, `EN_PRESENT -> EN_ABSENT` and `EN_ABSENT -> EN_PRESENT` follow the signal. Each flag is a two-state machine. `FL_IDLE -> FL_LATCHED` is taken on its set event. `FL_LATCHED -> FL_IDLE` is taken on a clear that is valid for the active scheme, and only when no set event occurs in the same cycle.

Top module: `phy_irq_ctrl`

## Requirements
- R1: Flag bit map: 0 wake match, 1 page received, 2 parallel-detection fault, 3 partner acknowledge, 4 link down, 5 remote fault, 6 reserved (always reads 0), 7 energy. After synchronous reset all flags are 0 except bit 7, which is 1, and `energy_on_o` is 1.
- R2: The remote-fault flag sets on a rising `rfault_i`. It clears on a falling `rfault_i`, a read of register 1 or a read of register 29.
- R3: The link-down flag sets on a falling `link_i`. It clears only on a read of register 1 or register 29. A rising `link_i` leaves it set.
- R4: The partner-acknowledge flag sets on a rising `lp_ack_i`. It clears on a falling `lp_ack_i` or a read of register 29. A read of register 1 leaves it set.
- R5: The parallel-detection-fault and page-received flags each set on the rising edge of their input. Each clears on its falling edge, a read of register 6, a read of register 29, `restart_an_i`, or a falling `link_i`.
- R6: The wake term is the OR of `wake_ctl_i[7:4] & wake_ctl_i[3:0]`. Its flag sets on the term's rising edge and clears on its falling edge or a read of register 29.
- R7: `energy_on_o` stays 1 from reset until `ACQ_CYCLES` cycles pass with `energy_sig_i` low, then drops to 0. After that it follows `energy_sig_i` one cycle later. The energy flag sets on the rise of `energy_on_o` and clears on its fall or a read of register 29.
- R8: `irq_o` is the OR of `flags_o & mask_i`. Flags latch whatever their mask.
- R9: When a set event and a clear trigger hit the same flag in the same cycle, the flag ends set.
- R10: With `alt_mode_i` high, the primary clearing triggers have no effect. A `w1c_i` strobe with data bit i set clears flag i only if that flag's source is inactive; otherwise the flag stays 1.
- R11: With `alt_mode_i` low, `w1c_i` writes have no effect on the flags.
- R12: Status levels already present when reset is released produce no set or clear events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rfault_i | input | 1 | Remote fault status |
| link_i | input | 1 | Internal link status |
| lp_ack_i | input | 1 | Link-partner acknowledge status |
| pd_fault_i | input | 1 | Parallel-detection fault status |
| page_rx_i | input | 1 | Page received status |
| energy_sig_i | input | 1 | Raw signal-present indication |
| wake_ctl_i | input | 8 | Wakeup control/status register contents |
| rd_reg1_i | input | 1 | Read strobe, register 1 |
| rd_reg6_i | input | 1 | Read strobe, register 6 |
| rd_reg29_i | input | 1 | Read strobe, register 29 |
| restart_an_i | input | 1 | Auto-negotiation restart strobe |
| alt_mode_i | input | 1 | Selects the write-one-to-clear scheme |
| mask_i | input | 8 | Interrupt mask, one bit per flag |
| w1c_i | input | 1 | Flag-register write strobe |
| w1c_data_i | input | 8 | Flag-register write data |
| flags_o | output | 8 | Source flags |
| energy_on_o | output | 1 | Energy-on status |
| irq_o | output | 1 | Interrupt output |

## Verification
A flag's set event and one of its clear triggers can land on the same clock edge. Examples are a status bit rising together with a register-6 or register-29 read, and a link loss that clears the fault flags while it sets the link-down flag. The stimulus table holds rows that raise a status input and pulse a clearing read in that one cycle. The flags sampled after that edge must show the bit set. A separate row drops the link while both detection flags are latched; it must leave only the link-down bit set.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int FLAG_W    = 8;
    localparam int WAKE_HALF = 4;

    // flag bit positions
    localparam int F_WAKE   = 0;
    localparam int F_PAGE   = 1;
    localparam int F_PDF    = 2;
    localparam int F_LPACK  = 3;
    localparam int F_LDOWN  = 4;
    localparam int F_RFAULT = 5;
    localparam int F_RSVD   = 6;
    localparam int F_ENERGY = 7;

    // positions inside the watched level vector
    localparam int L_RF   = 0;
    localparam int L_LINK = 1;
    localparam int L_LP   = 2;
    localparam int L_PD   = 3;
    localparam int L_PG   = 4;
    localparam int L_WAKE = 5;
    localparam int L_EN   = 6;
    localparam int LVL_W  = 7;

    typedef enum logic [1:0] {
        EN_ACQUIRE = 2'd0,
        EN_PRESENT = 2'd1,
        EN_ABSENT  = 2'd2
    } energy_state_e;

    typedef enum logic {
        FL_IDLE    = 1'b0,
        FL_LATCHED = 1'b1
    } flag_state_e;

    function automatic logic set_event(input int idx,
                                       input logic [LVL_W-1:0] rise,
                                       input logic [LVL_W-1:0] fall);
        logic r;
        case (idx)
            F_WAKE:   r = rise[L_WAKE];
            F_PAGE:   r = rise[L_PG];
            F_PDF:    r = rise[L_PD];
            F_LPACK:  r = rise[L_LP];
            F_LDOWN:  r = fall[L_LINK];
            F_RFAULT: r = rise[L_RF];
            F_ENERGY: r = rise[L_EN];
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic clr_event(input int idx,
                                       input logic [LVL_W-1:0] fall,
                                       input logic rd1,
                                       input logic rd6,
                                       input logic rd29,
                                       input logic renego);
        logic r;
        case (idx)
            F_WAKE:   r = fall[L_WAKE] | rd29;
            F_PAGE:   r = fall[L_PG] | rd6 | rd29 | renego | fall[L_LINK];
            F_PDF:    r = fall[L_PD] | rd6 | rd29 | renego | fall[L_LINK];
            F_LPACK:  r = fall[L_LP] | rd29;
            F_LDOWN:  r = rd1 | rd29;
            F_RFAULT: r = fall[L_RF] | rd1 | rd29;
            F_ENERGY: r = fall[L_EN] | rd29;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic src_active(input int idx,
                                        input logic [LVL_W-1:0] lvl);
        logic r;
        case (idx)
            F_WAKE:   r = lvl[L_WAKE];
            F_PAGE:   r = lvl[L_PG];
            F_PDF:    r = lvl[L_PD];
            F_LPACK:  r = lvl[L_LP];
            F_LDOWN:  r = ~lvl[L_LINK];
            F_RFAULT: r = lvl[L_RF];
            F_ENERGY: r = lvl[L_EN];
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_q;
    logic         primed_q;

    // the first cycle after reset only captures the levels (R12)
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= lvl;
            primed_q <= 1'b1;
        end
    end

    assign rise = primed_q ? (lvl & ~prev_q) : '0;
    assign fall = primed_q ? (~lvl & prev_q) : '0;

endmodule

// File: rtl/irq_energy_fsm.sv
module irq_energy_fsm
    import phy_irq_pkg::*;
#(
    parameter int ACQ_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic energy_on
);

    localparam int CNT_W = $clog2(ACQ_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ACQ_CYCLES - 1);

    energy_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic timeout;

    assign timeout = (cnt_q == LIMIT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EN_ACQUIRE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == EN_ACQUIRE && !timeout)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_ACQUIRE: begin
                if (sig)          state_d = EN_PRESENT;
                else if (timeout) state_d = EN_ABSENT;
            end
            EN_PRESENT: if (!sig) state_d = EN_ABSENT;
            EN_ABSENT:  if (sig)  state_d = EN_PRESENT;
            default:              state_d = EN_ACQUIRE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            EN_ACQUIRE: energy_on = 1'b1;
            EN_PRESENT: energy_on = 1'b1;
            EN_ABSENT:  energy_on = 1'b0;
            default:    energy_on = 1'b1;
        endcase
    end

    a_r7_timeout_drops: assert property (@(posedge clk) disable iff (rst)
        (state_q == EN_ACQUIRE && timeout && !sig) |=> !energy_on);

    a_r7_signal_restores: assert property (@(posedge clk) disable iff (rst)
        sig |=> energy_on);

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import phy_irq_pkg::*;
#(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic alt_mode,
    input  logic w1c,
    input  logic src_act,
    output logic flag
);

    flag_state_e state_q, state_d;
    logic drop;

    // a clear valid for the active scheme
    assign drop = alt_mode ? (w1c && !src_act) : clr_ev;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RST_VAL ? FL_LATCHED : FL_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:    if (set_ev)          state_d = FL_LATCHED;
            FL_LATCHED: if (drop && !set_ev) state_d = FL_IDLE;
            default:                         state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FL_LATCHED: flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag);

    a_r2_primary_clear: assert property (@(posedge clk) disable iff (rst)
        (!alt_mode && clr_ev && !set_ev) |=> !flag);

    a_r10_alt_keeps_active: assert property (@(posedge clk) disable iff (rst)
        (alt_mode && flag && src_act) |=> flag);

    a_r11_primary_ignores_write: assert property (@(posedge clk) disable iff (rst)
        (!alt_mode && !clr_ev && flag) |=> flag);

endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
    import phy_irq_pkg::*;
#(
    parameter int ACQ_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rfault_i,
    input  logic              link_i,
    input  logic              lp_ack_i,
    input  logic              pd_fault_i,
    input  logic              page_rx_i,
    input  logic              energy_sig_i,
    input  logic [7:0]        wake_ctl_i,
    input  logic              rd_reg1_i,
    input  logic              rd_reg6_i,
    input  logic              rd_reg29_i,
    input  logic              restart_an_i,
    input  logic              alt_mode_i,
    input  logic [FLAG_W-1:0] mask_i,
    input  logic              w1c_i,
    input  logic [FLAG_W-1:0] w1c_data_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              energy_on_o,
    output logic              irq_o
);

    logic             wake_term;
    logic [LVL_W-1:0] lvl, rise, fall;

    assign wake_term = |(wake_ctl_i[2*WAKE_HALF-1:WAKE_HALF] & wake_ctl_i[WAKE_HALF-1:0]);

    irq_energy_fsm #(.ACQ_CYCLES(ACQ_CYCLES)) u_energy (
        .clk       (clk),
        .rst       (rst),
        .sig       (energy_sig_i),
        .energy_on (energy_on_o)
    );

    always_comb begin
        lvl         = '0;
        lvl[L_RF]   = rfault_i;
        lvl[L_LINK] = link_i;
        lvl[L_LP]   = lp_ack_i;
        lvl[L_PD]   = pd_fault_i;
        lvl[L_PG]   = page_rx_i;
        lvl[L_WAKE] = wake_term;
        lvl[L_EN]   = energy_on_o;
    end

    irq_edge_det #(.W(LVL_W)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (i == F_RSVD) begin : g_rsvd
            assign flags_o[i] = 1'b0;
        end else begin : g_cell
            logic s_ev, c_ev, s_act;
            assign s_ev  = set_event(i, rise, fall);
            assign c_ev  = clr_event(i, fall, rd_reg1_i, rd_reg6_i, rd_reg29_i, restart_an_i);
            assign s_act = src_active(i, lvl);

            irq_flag_cell #(.RST_VAL((i == F_ENERGY) ? 1'b1 : 1'b0)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .set_ev   (s_ev),
                .clr_ev   (c_ev),
                .alt_mode (alt_mode_i),
                .w1c      (w1c_i & w1c_data_i[i]),
                .src_act  (s_act),
                .flag     (flags_o[i])
            );
        end
    end

    assign irq_o = |(flags_o & mask_i);

    a_r8_no_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_i == '0) |-> !irq_o);

    a_r3_link_loss_sets: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(link_i)) |=> flags_o[F_LDOWN]);

    a_r5_link_loss_clears: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(link_i) && !alt_mode_i && $past(pd_fault_i) && pd_fault_i)
        |=> !flags_o[F_PDF]);

    a_r1_reserved_low: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[F_RFAULT]) |-> !flags_o[F_RSVD]);

endmodule

// File: tb/phy_irq_ctrl_test.sv
`timescale 1ns/100ps
module phy_irq_ctrl_test;

    typedef struct packed {
        logic       rf, lk, lp, pd, pg;
        logic [7:0] wake;
        logic       r1, r6, r29, an;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h20,4'd2}, // R2 set
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,4'd2}, // R2 reg1
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd2},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h20,4'd2},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd2}, // R2 fall
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h20,4'd2},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,4'd2}, // R2 reg29
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h10,4'd3}, // R3 set
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h10,4'd3}, // R3 rise keeps
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,4'd3},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h08,4'd4}, // R4 set
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h08,4'd4}, // R4 reg1 no effect
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,4'd4},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd4},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h08,4'd4},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd4},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,4'd5}, // R5 set
        '{1'b0,1'b1,1'b0,1'b1,1'b1,8'h00,1'b0,1'b1,1'b0,1'b0,8'h00,4'd5}, // R5 reg6
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,4'd5},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,1'b1,8'h00,4'd5}, // R5 restart
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,4'd5},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h10,4'd5}, // R5 link loss
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h10,4'd3},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,4'd3},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h11,1'b0,1'b0,1'b0,1'b0,8'h01,4'd6}, // R6 set
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h10,1'b0,1'b0,1'b0,1'b0,8'h00,4'd6}, // R6 fall
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h82,1'b0,1'b0,1'b0,1'b0,8'h00,4'd6}, // R6 no overlap
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h88,1'b0,1'b0,1'b0,1'b0,8'h01,4'd6},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h88,1'b0,1'b0,1'b1,1'b0,8'h00,4'd6}, // R6 reg29
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd6},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h04,4'd9}, // R9 rise+reg6
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h20,4'd9}, // R9 rise+reg29
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,4'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rfault = 1'b0, link = 1'b1, lp_ack = 1'b0, pd_fault = 1'b0, page_rx = 1'b0;
    logic       energy_sig = 1'b0;
    logic [7:0] wake_ctl = 8'h00;
    logic       rd1 = 1'b0, rd6 = 1'b0, rd29 = 1'b0, restart_an = 1'b0;
    logic       alt_mode = 1'b0;
    logic [7:0] mask = 8'h00;
    logic       w1c = 1'b0;
    logic [7:0] w1c_data = 8'h00;
    logic [7:0] flags;
    logic       energy_on, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phy_irq_ctrl #(.ACQ_CYCLES(20)) uut (
        .clk (clk), .rst (rst),
        .rfault_i (rfault), .link_i (link), .lp_ack_i (lp_ack),
        .pd_fault_i (pd_fault), .page_rx_i (page_rx), .energy_sig_i (energy_sig),
        .wake_ctl_i (wake_ctl),
        .rd_reg1_i (rd1), .rd_reg6_i (rd6), .rd_reg29_i (rd29), .restart_an_i (restart_an),
        .alt_mode_i (alt_mode), .mask_i (mask),
        .w1c_i (w1c), .w1c_data_i (w1c_data),
        .flags_o (flags), .energy_on_o (energy_on), .irq_o (irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_one(input logic [7:0] d);
        w1c = 1'b1; w1c_data = d;
        step();
        w1c = 1'b0; w1c_data = 8'h00;
    endtask

    task automatic pulse_rd1();
        rd1 = 1'b1; step(); rd1 = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state (R1)
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1", "flags after reset", flags, 8'h80);
        chk("R1", "energy_on after reset", {7'd0, energy_on}, 8'h01);
        chk("R1", "irq after reset", {7'd0, irq}, 8'h00);

        // acquisition time-out (R7)
        repeat (25) step();
        chk("R7", "energy_on after time-out", {7'd0, energy_on}, 8'h00);
        chk("R7", "flags after time-out", flags, 8'h00);

        // stimulus table
        for (int i = 0; i < NV; i++) begin
            rfault = VEC[i].rf; link = VEC[i].lk; lp_ack = VEC[i].lp;
            pd_fault = VEC[i].pd; page_rx = VEC[i].pg; wake_ctl = VEC[i].wake;
            rd1 = VEC[i].r1; rd6 = VEC[i].r6; rd29 = VEC[i].r29; restart_an = VEC[i].an;
            step();
            chk($sformatf("R%0d", VEC[i].req), $sformatf("table row %0d", i), flags, VEC[i].exp);
        end
        rd1 = 1'b0; rd6 = 1'b0; rd29 = 1'b0; restart_an = 1'b0;

        // masking (R8)
        rfault = 1'b1; step();
        chk("R8", "flag latched while masked", flags, 8'h20);
        chk("R8", "irq with empty mask", {7'd0, irq}, 8'h00);
        mask = 8'h20; #1;
        chk("R8", "irq with matching mask", {7'd0, irq}, 8'h01);
        mask = 8'h10; #1;
        chk("R8", "irq with other mask", {7'd0, irq}, 8'h00);
        rfault = 1'b0; step();
        mask = 8'h00;
        chk("R2", "flags after fall", flags, 8'h00);

        // primary mode ignores writes (R11)
        link = 1'b0; step();
        link = 1'b1; step();
        write_one(8'h10);
        chk("R11", "write in primary mode", flags, 8'h10);
        pulse_rd1();
        chk("R3", "reg1 read clears", flags, 8'h00);

        // alternate mode (R10)
        alt_mode = 1'b1;
        link = 1'b0; step();
        chk("R10", "link-down set in alt mode", flags, 8'h10);
        write_one(8'h10);
        chk("R10", "write while source active", flags, 8'h10);
        pulse_rd1();
        chk("R10", "reg1 read ignored", flags, 8'h10);
        link = 1'b1; step();
        write_one(8'h10);
        chk("R10", "write after source idle", flags, 8'h00);
        rfault = 1'b1; step();
        rfault = 1'b0; step();
        chk("R10", "source fall ignored", flags, 8'h20);
        write_one(8'h20);
        chk("R10", "write clears remote fault", flags, 8'h00);
        alt_mode = 1'b0;

        // energy path (R7)
        energy_sig = 1'b1; step();
        chk("R7", "energy_on follows signal", {7'd0, energy_on}, 8'h01);
        step();
        chk("R7", "energy flag set", flags, 8'h80);
        rd29 = 1'b1; step(); rd29 = 1'b0;
        chk("R7", "reg29 read clears energy flag", flags, 8'h00);
        energy_sig = 1'b0; step();
        chk("R7", "energy_on drops", {7'd0, energy_on}, 8'h00);
        energy_sig = 1'b1; step(); step();
        chk("R7", "energy flag set again", flags, 8'h80);
        energy_sig = 1'b0; step(); step();
        chk("R7", "energy fall clears flag", flags, 8'h00);

        // levels held through reset give no events (R12)
        rfault = 1'b1; link = 1'b0; pd_fault = 1'b1;
        rst = 1'b1; step(); step();
        rst = 1'b0; step(); step();
        chk("R12", "no events from held levels", flags, 8'h80);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule